// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Unit

This block decides, every cycle, how an in-order five-stage integer pipeline (fetch, decode, execute, memory, write-back) handles register dependences and taken branches. It compares the two source register numbers of the instruction about to execute with the destination registers of the two older instructions still in flight. From that it drives a bypass select for each ALU operand. It also detects the one dependence that bypassing cannot cover: a load whose data is needed by the very next instruction. In that case it freezes fetch and decode for one cycle and sends a bubble into execute.

The unit is purely combinational. Its inputs are register numbers, write-enable flags, a load flag and the branch outcome from execute. Its outputs drive the operand multiplexers and the enables of the PC, IF/ID and ID/EX registers. The register file writes in the first half of a cycle and reads in the second half, so a producer in write-back is already visible to an instruction in decode. The bypass network therefore spans exactly two stages. Only read-after-write dependences produce a bypass or a stall. Two reads of the same register never do.

All ports are plain control pins. No data stream passes through the unit, so there is no valid/ready handshake and no back-pressure.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An ALU operand select is 01 (take from EX/MEM) when the EX/MEM instruction writes (`mem_wen`=1) a nonzero register equal to that operand's source number in ID/EX.
- R2: An operand select is 10 (take from MEM/WB) when the MEM/WB instruction writes a nonzero register equal to that operand's source number and R1 does not apply.
- R3: When EX/MEM and MEM/WB both write the register an operand reads, the select is 01, so the younger result wins.
- R4: Register 0 never produces a select other than 00 and never causes a stall, whatever the write flags are.
- R5: An operand select is 00 (register file) when no in-flight writer matches its source. This includes a matching register number whose write flag is 0, as in a read followed by a read.
- R6: A load in ID/EX (`ex_is_load`=1, `ex_wen`=1, nonzero `ex_rd`) whose destination equals either decode source drives `pc_we`=0, `ifid_we`=0, `idex_bubble`=1 and `ifid_flush`=0.
- R7: A non-load instruction in ID/EX whose destination matches a decode source causes no stall: `pc_we`=1 and `ifid_we`=1.
- R8: `ex_br_taken`=1 drives `ifid_flush`=1, `idex_bubble`=1, `pc_we`=1 and `ifid_we`=1. The branch overrides any load-use stall detected in the same cycle.
- R9: With no load-use hazard and no taken branch, `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `ifid_flush`=0.
- R10: In a chain of four consumers that follow one producer back to back, the first consumer gets 01, the second gets 10, and the third and fourth get 00 because the register file already holds the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source register of the instruction in IF/ID (decode) |
| id_rs2 | input | AW | Second source register of the instruction in IF/ID |
| ex_rs1 | input | AW | First source register of the instruction in ID/EX |
| ex_rs2 | input | AW | Second source register of the instruction in ID/EX |
| ex_rd | input | AW | Destination register of the instruction in ID/EX |
| ex_wen | input | 1 | The ID/EX instruction writes a register |
| ex_is_load | input | 1 | The ID/EX instruction is a load |
| mem_rd | input | AW | Destination register of the instruction in EX/MEM |
| mem_wen | input | 1 | The EX/MEM instruction writes a register |
| wb_rd | input | AW | Destination register of the instruction in MEM/WB |
| wb_wen | input | 1 | The MEM/WB instruction writes a register |
| ex_br_taken | input | 1 | The branch in execute was resolved as taken |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 EX/MEM, 10 MEM/WB |
| fwd_b | output | 2 | Operand B select, same encoding as fwd_a |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_bubble | output | 1 | Clear the control bits entering ID/EX |
| ifid_flush | output | 1 | Clear the IF/ID register |

## Verification
A wrong bypass priority or a missed register-0 guard shows as a wrong select code in the same cycle the register numbers are applied. The block has no state, so each error appears immediately and nothing persists to mask it. A broken load-use comparator shows either as a freeze with no cause or as a missing freeze, and a wrong flush priority shows as a frozen PC during a taken branch. The bench compares every output against its own model after each new input vector. It covers random register numbers drawn from a narrow range to force matches, plus directed dependence chains.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;

endpackage

// File: rtl/hzu_fwd_pick.sv
module hzu_fwd_pick
  import hzu_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);

  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wen && (mem_rd == src);
  assign hit_wb   = src_live && wb_wen  && (wb_rd  == src);

  // younger producer first
  always_comb begin
    if (hit_mem)     sel = FWD_EXMEM;
    else if (hit_wb) sel = FWD_MEMWB;
    else             sel = FWD_RF;
  end

  always_comb begin
    if (src == '0) begin
      assert_zero_never_fwd_R4: assert (sel == FWD_RF)
        else $error("register 0 forwarded");
    end
    if (mem_wen && (mem_rd == src) && (src != '0)) begin
      assert_exmem_first_R3: assert (sel == FWD_EXMEM)
        else $error("EX/MEM match lost priority");
    end
  end

endmodule

// File: rtl/hzu_load_use.sv
module hzu_load_use
  import hzu_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = NUM_SRC
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_wen,
  input  logic                    ex_is_load,
  output logic                    hazard
);

  logic [NSRC-1:0] src_hit;
  logic            load_live;

  assign load_live = ex_is_load && ex_wen && (ex_rd != '0);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = load_live && (id_src[s] == ex_rd);
  end

  assign hazard = |src_hit;

  always_comb begin
    if (hazard) begin
      assert_stall_only_for_load_R7: assert (ex_is_load && (ex_rd != '0))
        else $error("stall without a live load");
    end
  end

endmodule

// File: rtl/hzu_flow_ctrl.sv
module hzu_flow_ctrl (
  input  logic load_hazard,
  input  logic br_taken,
  output logic pc_we,
  output logic ifid_we,
  output logic idex_bubble,
  output logic ifid_flush
);

  logic freeze;

  // a taken branch discards the decode slot, so its stall is moot
  assign freeze      = load_hazard && !br_taken;
  assign pc_we       = !freeze;
  assign ifid_we     = !freeze;
  assign ifid_flush  = br_taken;
  assign idex_bubble = freeze || br_taken;

  always_comb begin
    if (br_taken) begin
      assert_branch_keeps_fetch_R8: assert (pc_we && ifid_we && ifid_flush)
        else $error("taken branch froze fetch");
    end
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzu_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  input  logic          ex_br_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble,
  output logic          ifid_flush
);

  localparam int unsigned NSRC = NUM_SRC;

  logic [NSRC-1:0][AW-1:0] ex_src;
  logic [NSRC-1:0][AW-1:0] id_src;
  fwd_sel_e [NSRC-1:0]     sel;
  logic                    load_hazard;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    hzu_fwd_pick #(.AW(AW)) u_pick (
      .src     (ex_src[s]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel[s])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hzu_load_use #(.AW(AW), .NSRC(NSRC)) u_load_use (
    .id_src     (id_src),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_is_load (ex_is_load),
    .hazard     (load_hazard)
  );

  hzu_flow_ctrl u_flow (
    .load_hazard (load_hazard),
    .br_taken    (ex_br_taken),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush)
  );

  always_comb begin
    assert_hold_pair_R6: assert (pc_we == ifid_we)
      else $error("PC and IF/ID enables disagree");
    if (!pc_we) begin
      assert_freeze_bubbles_R6: assert (idex_bubble && !ifid_flush)
        else $error("freeze without bubble");
    end
    if (load_hazard == 1'b0 && ex_br_taken == 1'b0) begin
      assert_quiet_flow_R9: assert (pc_we && !idex_bubble && !ifid_flush)
        else $error("control active without cause");
    end
  end

endmodule

// File: tb/test_pipe_hazard_unit.sv
module test_pipe_hazard_unit;

  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_is_load, mem_wen, wb_wen, ex_br_taken;
  logic [1:0] fwd_a, fwd_b;
  logic pc_we, ifid_we, idex_bubble, ifid_flush;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  pipe_hazard_unit #(.AW(AW)) i_pipe_hazard_unit (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .wb_rd(wb_rd), .wb_wen(wb_wen),
    .ex_br_taken(ex_br_taken), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush)
  );

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s);
    if (s != 0 && mem_wen && mem_rd == s) return 2'b01;
    if (s != 0 && wb_wen && wb_rd == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    return ex_is_load && ex_wen && ex_rd != 0 &&
           (ex_rd == id_rs1 || ex_rd == id_rs2) && !ex_br_taken;
  endfunction

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clear();
    id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0; mem_rd = 0;
    wb_rd = 0; ex_wen = 0; ex_is_load = 0; mem_wen = 0; wb_wen = 0;
    ex_br_taken = 0;
  endtask

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_ctrl(string req);
    logic s;
    s = exp_stall();
    chk({req, " ctrl"}, {pc_we, ifid_we, idex_bubble, ifid_flush},
        {!s, !s, s || ex_br_taken, ex_br_taken});
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk); clear(); settle();
    // R9 idle state
    chk("R9 idle", {pc_we, ifid_we, idex_bubble, ifid_flush}, 4'b1100);
    chk("R5 idle fwd", {fwd_a, fwd_b}, 4'b0000);

    // R1 EX/MEM hit on A, R2 MEM/WB hit on B
    @(negedge clk); clear(); ex_rs1 = 3; ex_rs2 = 7; mem_rd = 3; mem_wen = 1;
    wb_rd = 7; wb_wen = 1; settle();
    chk("R1 fwd_a", {2'b0, fwd_a}, 4'd1);
    chk("R2 fwd_b", {2'b0, fwd_b}, 4'd2);

    // R3 both match
    @(negedge clk); clear(); ex_rs1 = 9; ex_rs2 = 9; mem_rd = 9; mem_wen = 1;
    wb_rd = 9; wb_wen = 1; settle();
    chk("R3 priority", {fwd_a, fwd_b}, 4'b0101);

    // R4 register 0
    @(negedge clk); clear(); mem_wen = 1; wb_wen = 1; ex_wen = 1; ex_is_load = 1;
    settle();
    chk("R4 zero fwd", {fwd_a, fwd_b}, 4'b0000);
    chk("R4 zero stall", {pc_we, ifid_we, idex_bubble, ifid_flush}, 4'b1100);

    // R5 match but no write (read after read)
    @(negedge clk); clear(); ex_rs1 = 4; ex_rs2 = 4; mem_rd = 4; wb_rd = 4;
    settle();
    chk("R5 no write", {fwd_a, fwd_b}, 4'b0000);

    // R6 load-use on second source
    @(negedge clk); clear(); id_rs2 = 6; ex_rd = 6; ex_wen = 1; ex_is_load = 1;
    settle();
    chk("R6 load-use", {pc_we, ifid_we, idex_bubble, ifid_flush}, 4'b0010);

    // R7 same match, not a load
    @(negedge clk); ex_is_load = 0; settle();
    chk("R7 alu no stall", {pc_we, ifid_we, idex_bubble, ifid_flush}, 4'b1100);

    // R8 branch overrides load-use
    @(negedge clk); ex_is_load = 1; ex_br_taken = 1; settle();
    chk("R8 branch", {pc_we, ifid_we, idex_bubble, ifid_flush}, 4'b1111);

    // R10 four consumers of r1: producer moves EX/MEM, MEM/WB, then retires
    @(negedge clk); clear(); ex_rs1 = 1; ex_rs2 = 2; mem_rd = 1; mem_wen = 1;
    settle();
    chk("R10 consumer1", {2'b0, fwd_a}, 4'd1);
    @(negedge clk); clear(); ex_rs1 = 1; ex_rs2 = 7; mem_rd = 4; mem_wen = 1;
    wb_rd = 1; wb_wen = 1; settle();
    chk("R10 consumer2", {2'b0, fwd_a}, 4'd2);
    @(negedge clk); clear(); ex_rs1 = 1; ex_rs2 = 9; mem_rd = 6; mem_wen = 1;
    wb_rd = 4; wb_wen = 1; settle();
    chk("R10 consumer3", {2'b0, fwd_a}, 4'd0);
    @(negedge clk); clear(); ex_rs1 = 11; ex_rs2 = 1; mem_rd = 8; mem_wen = 1;
    wb_rd = 6; wb_wen = 1; settle();
    chk("R10 consumer4", {2'b0, fwd_b}, 4'd0);

    // random sweep over a narrow register range to force matches
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      id_rs1 = AW'($urandom_range(0, 3)); id_rs2 = AW'($urandom_range(0, 3));
      ex_rs1 = AW'($urandom_range(0, 3)); ex_rs2 = AW'($urandom_range(0, 3));
      ex_rd  = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      wb_rd  = AW'($urandom_range(0, 3));
      ex_wen = 1'($urandom); ex_is_load = 1'($urandom);
      mem_wen = 1'($urandom); wb_wen = 1'($urandom);
      ex_br_taken = ($urandom_range(0, 7) == 0);
      settle();
      chk("R1 R2 R3 rand fwd_a", {2'b0, fwd_a}, {2'b0, exp_sel(ex_rs1)});
      chk("R1 R2 R3 rand fwd_b", {2'b0, fwd_b}, {2'b0, exp_sel(ex_rs2)});
      chk_ctrl("R6 R7 R8 R9 rand");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule